// File: doc/BRIEF.md
# Two-Wire Bus Master Serial Clock Generator

This block produces the serial clock of a two-wire serial bus controller while that controller is the bus master. Software programs a clock divisor and an enable bit through two byte-wide registers. The block times the low and the high phase of the clock from its own input clock. It drives the line open-drain style, so it only ever asserts a pull-low enable. It also watches the wired clock line, so it stays in step with any other device that holds the line low or pulls it low early.

The shift and framing logic raises `run` to request clock periods and drops it to stop. When `run` falls, the period in progress completes and the line is left released. Three single-cycle strobes tell the shift logic where each falling edge falls, where each rising edge is seen, and where the middle of each high phase lies, which is the point to sample data. Clearing the enable bit stops the clock at once and clears both registers.

Top module: `scl_clock_gen`

## Requirements
- R1: A write with `wr_sel`=0 loads the low register: bit 0 is the enable and bits 7:1 are divisor bits 6:0. A write with `wr_sel`=1 loads the high register, which holds divisor bits 14:7. `rd_data` returns the low register when `rd_sel`=0 and the high register when `rd_sel`=1.
- R2: Both registers reset to 00h. A low-register write with bit 0 = 0 clears both registers. A write to the high register while the enable is 0 has no effect, and the high register reads back 00h.
- R3: `scl_oe` is 0 while the enable is 0 and while the block is idle. Clearing the enable during a running period drops `scl_oe` on the second clock edge after the write edge.
- R4: Each low phase holds `scl_oe`=1 for exactly 2 × divisor input clock cycles.
- R5: When no other device drives the line, each high phase keeps `scl_oe`=0 for exactly 2 × divisor cycles.
- R6: A divisor value below 8, taken over the whole 15-bit field, is used as 8. A value of 8 or more is used as written, including values whose low 7 bits are below 8.
- R7: If the line stays low after the block releases it, the high phase is stretched. `rise_tick` appears 3 cycles after the line goes high, and `scl_oe` rises 2 × divisor cycles after the line goes high.
- R8: If another device pulls the line low during the high phase, the block ends that phase and asserts `scl_oe` 3 cycles later, with `fall_tick` in that same cycle.
- R9: `fall_tick` is high in the first cycle of each low phase. On a quiet bus, `rise_tick` is high in the 4th released cycle and `mid_tick` is high in released cycle index equal to the divisor, counting from index 0. At most one strobe is high in any cycle.
- R10: A period starts the cycle after `run` is seen high while enabled. After `run` falls, the current period completes and `scl_oe` then stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 low register, 1 high register |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 low register, 1 high register |
| rd_data | output | 8 | Selected register contents |
| run | input | 1 | Request clock generation |
| scl_in | input | 1 | Sampled level of the wired clock line |
| scl_oe | output | 1 | Pull-low enable for the clock line |
| fall_tick | output | 1 | First cycle of a low phase |
| rise_tick | output | 1 | First cycle in which the high phase counts |
| mid_tick | output | 1 | Middle of the high phase |

## Verification
A register write takes effect one edge after its strobe, and a read is combinational. Phase lengths are counted at falling clock edges as the number of samples for which `scl_oe` holds a level. Line events that the bench injects through its wired-AND model are due 3 sampled cycles later, because of the two-flop synchronizer plus one state edge. The bench therefore applies each stimulus at a falling edge and checks each result at the exact sample index that these latencies give, never within a window.

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int MIN_DIV = 8,
  parameter int SYNC_W  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  input  logic       run,
  input  logic       scl_in,
  output logic       scl_oe,
  output logic       fall_tick,
  output logic       rise_tick,
  output logic       mid_tick
);
  localparam int DIV_W = 15;
  localparam int CNT_W = DIV_W + 2;
  localparam int LAT   = SYNC_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_WAIT, S_HIGH} st_t;

  logic [7:0]       lo_q, hi_q;
  logic             en;
  logic [DIV_W-1:0] div_raw, div_eff;
  logic [CNT_W-1:0] phase, lo_end, hi_end, mid_pt, cnt;
  logic [SYNC_W-1:0] sync_q;
  logic             scl_s;
  st_t              st;

  assign en      = lo_q[0];
  assign rd_data = rd_sel ? hi_q : lo_q;

  // R1 R2: register pair; clearing the enable wipes both
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_en && !wr_sel) begin
      lo_q <= wr_data[0] ? wr_data : 8'h00;
      if (!wr_data[0]) hi_q <= '0;
    end else if (wr_en && wr_sel && en) begin
      hi_q <= wr_data;
    end
  end

  // R6: clamp into the legal range
  assign div_raw = {hi_q, lo_q[7:1]};
  assign div_eff = (div_raw < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_raw;
  assign phase   = {1'b0, div_eff, 1'b0};
  assign lo_end  = phase - CNT_W'(1);
  assign hi_end  = phase - CNT_W'(LAT + 1);
  assign mid_pt  = CNT_W'(div_eff) - CNT_W'(LAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_W-2:0], scl_in};
  end
  assign scl_s = sync_q[SYNC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      scl_oe <= 1'b0;
    end else if (!en) begin
      st     <= S_IDLE;
      cnt    <= '0;
      scl_oe <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (run) begin
          st     <= S_LOW;
          cnt    <= '0;
          scl_oe <= 1'b1;
        end
        S_LOW: if (cnt >= lo_end) begin
          st     <= S_WAIT;
          cnt    <= '0;
          scl_oe <= 1'b0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        S_WAIT: if (scl_s) begin
          st  <= S_HIGH;
          cnt <= '0;
        end
        S_HIGH: if (!scl_s || cnt >= hi_end) begin
          cnt <= '0;
          if (run) begin
            st     <= S_LOW;
            scl_oe <= 1'b1;
          end else begin
            st <= S_IDLE;
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign fall_tick = (st == S_LOW)  && (cnt == '0);
  assign rise_tick = (st == S_HIGH) && (cnt == '0);
  assign mid_tick  = (st == S_HIGH) && (cnt == mid_pt);

  logic [CNT_W-1:0] lo_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lo_len <= '0;
    else if (scl_oe) lo_len <= lo_len + CNT_W'(1);
    else             lo_len <= '0;
  end

  p_regs_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (lo_q == 8'h00 && hi_q == 8'h00));
  p_off_when_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_oe);
  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !run) |=> !scl_oe);
  p_low_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $fell(scl_oe)) |-> lo_len == phase);
  p_sync_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run && st == S_HIGH && !scl_s) |=> (scl_oe && fall_tick));
  p_one_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_tick, rise_tick, mid_tick}));
  p_fall_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> scl_oe);
  p_rise_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_tick || mid_tick) |-> !scl_oe);
endmodule

// File: tb/scl_clock_gen_tb_top.sv
module scl_clock_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, run = 1'b0, ext_low = 1'b0;
  logic [7:0] wr_data = '0, rd_data;
  logic scl_in, scl_oe, fall_tick, rise_tick, mid_tick;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign scl_in = ~(scl_oe | ext_low);

  scl_clock_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .run(run), .scl_in(scl_in), .scl_oe(scl_oe),
    .fall_tick(fall_tick), .rise_tick(rise_tick), .mid_tick(mid_tick));

  // {low reg, high reg, expected phase length}
  localparam logic [31:0] VEC [7] = '{
    32'h11_00_0010, 32'h1B_00_001A, 32'h05_00_0010, 32'h01_00_0010,
    32'hFF_00_00FE, 32'h91_01_0190, 32'h01_01_0100 };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic sel, input int exp, input string req);
    rd_sel = sel; #1;
    chk(rd_data == exp[7:0], req, rd_data, exp);
  endtask

  task automatic wait_oe(input logic lvl);
    for (int k = 0; k < 100000 && scl_oe != lvl; k++) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    int n, ri, mi, half, dv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(scl_oe == 1'b0, "R3", scl_oe, 0);
    chk({fall_tick, rise_tick, mid_tick} == 3'b000, "R9", {fall_tick, rise_tick, mid_tick}, 0);
    rd_chk(1'b0, 0, "R2");
    rd_chk(1'b1, 0, "R2");
    // R2: high write ignored while disabled
    wr(1'b1, 8'h5A);
    rd_chk(1'b1, 0, "R2");
    // R1: layout and readback
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h5A);
    rd_chk(1'b0, 8'h11, "R1");
    rd_chk(1'b1, 8'h5A, "R1");
    // R2: clearing enable clears both
    wr(1'b0, 8'h10);
    rd_chk(1'b0, 0, "R2");
    rd_chk(1'b1, 0, "R2");
    // R3: enabled but idle
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h00);
    n = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); n += scl_oe; end
    chk(n == 0, "R3", n, 0);

    // table of divisor settings
    for (int i = 0; i < 7; i++) begin
      half = int'(VEC[i][15:0]);
      dv = half / 2;
      wr(1'b0, VEC[i][31:24]);
      wr(1'b1, VEC[i][23:16]);
      rd_chk(1'b1, int'(VEC[i][23:16]), "R1");
      @(negedge clk); run = 1'b1;
      @(negedge clk);
      chk(scl_oe == 1'b1, "R10", scl_oe, 1);
      chk(fall_tick == 1'b1, "R9", fall_tick, 1);
      n = 0;
      while (scl_oe && n < 100000) begin n++; @(negedge clk); end
      chk(n == half, "R4 R6", n, half);
      n = 0; ri = -1; mi = -1;
      while (!scl_oe && n < 100000) begin
        if (rise_tick) ri = n;
        if (mid_tick) mi = n;
        n++; @(negedge clk);
      end
      chk(n == half, "R5 R6", n, half);
      chk(ri == 3, "R9 rise", ri, 3);
      chk(mi == dv, "R9 mid", mi, dv);
      run = 1'b0;
      repeat (2 * half + 10) @(negedge clk);
      n = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); n += scl_oe; end
      chk(n == 0, "R10 stop", n, 0);
    end

    // R7: stretched high phase, divisor 8
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h00);
    @(negedge clk); run = 1'b1;
    wait_oe(1'b1);
    ext_low = 1'b1;
    wait_oe(1'b0);
    n = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); n += scl_oe + rise_tick; end
    chk(n == 0, "R7 hold", n, 0);
    ext_low = 1'b0;
    n = 0; ri = -1;
    while (!scl_oe && n < 100000) begin
      if (rise_tick) ri = n;
      @(negedge clk); n++;
    end
    chk(ri == 3, "R7 rise", ri, 3);
    chk(n == 16, "R7 high", n, 16);

    // R8: early pull low during high phase
    wait_oe(1'b0);
    repeat (6) @(negedge clk);
    ext_low = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(scl_oe == 1'b0, "R8 early", scl_oe, 0);
    @(negedge clk);
    chk(scl_oe == 1'b1, "R8", scl_oe, 1);
    chk(fall_tick == 1'b1, "R8 tick", fall_tick, 1);
    repeat (2) @(negedge clk);
    ext_low = 1'b0;

    // R3: disable while running
    wait_oe(1'b1);
    @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h10;
    @(negedge clk); wr_en = 1'b0;
    chk(scl_oe == 1'b1, "R3 lag", scl_oe, 1);
    @(negedge clk);
    chk(scl_oe == 1'b0, "R3 off", scl_oe, 0);
    n = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); n += scl_oe; end
    chk(n == 0, "R3 stays", n, 0);
    rd_chk(1'b0, 0, "R2 run");
    run = 1'b0;

    done = 1;
    summary();
    $finish;
  end
endmodule